// File: doc/BRIEF.md
# Serial Zero-Interleaving Bit Expander

This block turns a serial stream of single bits into a stream twice as long. Every bit it accepts becomes a fixed two-bit symbol. The symbol's bits then leave on one serial line, one bit per rising clock edge. The output runs at twice the accepted bit rate, so the input side uses a valid/ready handshake to hold off the producer. A small FIFO of encoded symbols absorbs bursts.

A mode input picks the mapping for each accepted bit. The first mapping inserts a zero after the original bit. The second emits a two-bit signed unit code. The mode is captured together with the bit, so changing it never alters symbols that are already queued. The output carries a valid flag. When nothing is queued the output is held at zero.

Top module: `bit_expander`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no input, out_valid is 0, out_bit is 0 and in_ready is 1.
- R2: With in_mode = 0 (zero insert), an accepted 1 is sent as 1 then 0, and an accepted 0 is sent as 0 then 0.
- R3: With in_mode = 1 (signed unit), an accepted 0 is sent as 1 then 1, and an accepted 1 is sent as 0 then 1.
- R4: One bit leaves per cycle with out_valid high. The second bit of a symbol always appears in the cycle right after its first bit.
- R5: When no symbol is queued, out_valid is 0 and out_bit is 0.
- R6: in_ready goes low when DEPTH symbols are queued and none is leaving. A producer that holds in_valid and in_bit through the stall loses no bit and sees no reordering.
- R7: When the FIFO is full, in_ready is high in the cycle where the second bit of the head symbol is sent, because a slot frees at that edge.
- R8: in_mode is sampled only at the edge that accepts a bit. Changing it afterwards does not alter symbols already queued.
- R9: Under a continuous input supply, the output carries no idle cycle from its first bit until the queue empties.
- R10: A bit accepted at an edge while the queue is empty shows its first output bit in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers in_bit |
| in_ready | output | 1 | Block can accept a bit at this edge |
| in_bit | input | 1 | Serial data bit |
| in_mode | input | 1 | Mapping for this bit: 0 zero insert, 1 signed unit |
| out_valid | output | 1 | out_bit carries a symbol bit |
| out_bit | output | 1 | Serial expanded output |

## Verification
The scoreboard is driven with single isolated bits of each value in both modes. These bits show the mapping and the one-cycle latency with no other traffic present. Long continuous bursts saturate the FIFO. They separate correct stall behaviour from lost or reordered bits, and they show whether a slot is released in the same cycle as the trailing bit. Bursts that alternate the mode bit by bit, issued while earlier symbols are still queued, show whether the mode was captured per bit or read at output time.

// File: rtl/bitexp_pkg.sv
package bitexp_pkg;

  typedef enum logic {
    MODE_ZERO_INSERT = 1'b0,
    MODE_SIGNED_UNIT = 1'b1
  } expandMode_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } pair_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic emit;
    logic selTrail;
  } ctrlStrobes_t;

  function automatic pair_t encodeBit(input logic dataBit, input expandMode_e mode);
    pair_t sym;
    if (mode == MODE_SIGNED_UNIT) begin
      sym.lead  = ~dataBit;
      sym.trail = 1'b1;
    end else begin
      sym.lead  = dataBit;
      sym.trail = 1'b0;
    end
    return sym;
  endfunction

endpackage

// File: rtl/bitexp_ctrl.sv
module bitexp_ctrl
  import bitexp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fillCount;
  logic             phaseTrail;

  always_comb begin
    strobes.emit     = (fillCount != '0);
    strobes.selTrail = phaseTrail;
    strobes.pop      = strobes.emit && phaseTrail;
    inReady          = (fillCount < FULL_CNT) || strobes.pop;
    strobes.push     = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCount  <= '0;
      phaseTrail <= 1'b0;
    end else begin
      fillCount  <= fillCount + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
      phaseTrail <= strobes.emit ? ~phaseTrail : 1'b0;
    end
  end

  // R6: occupancy never passes the storage size
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    fillCount <= FULL_CNT);

  // R4: a started symbol always finishes on the next cycle
  p_pair_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.emit && !phaseTrail) |=> (strobes.emit && phaseTrail));

  // R10: an accepted bit is on the line in the following cycle
  p_accept_shows_r10: assert property (@(posedge clk) disable iff (rst)
    strobes.push |=> strobes.emit);

  // R5: an empty queue stays empty without a push
  p_idle_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobes.emit && !inValid) |=> !strobes.emit);

endmodule

// File: rtl/bitexp_datapath.sv
module bitexp_datapath
  import bitexp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic         inBit,
  input  logic         inMode,
  output logic         outBit
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  pair_t            symStore [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  pair_t            headSym;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) symStore[wrPtr] <= encodeBit(inBit, expandMode_e'(inMode));
  end

  always_comb begin
    headSym = symStore[rdPtr];
    if (!strobes.emit)        outBit = 1'b0;
    else if (strobes.selTrail) outBit = headSym.trail;
    else                       outBit = headSym.lead;
  end

  // R4: the head symbol stays put between its two bits
  p_hold_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.emit && !strobes.selTrail) |=> $stable(rdPtr));

endmodule

// File: rtl/bit_expander.sv
module bit_expander
  import bitexp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_mode,
  output logic out_valid,
  output logic out_bit
);

  ctrlStrobes_t strobes;

  bitexp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (in_valid),
    .inReady (in_ready),
    .strobes (strobes)
  );

  bitexp_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inBit   (in_bit),
    .inMode  (in_mode),
    .outBit  (out_bit)
  );

  assign out_valid = strobes.emit;

endmodule

// File: tb/bit_expander_test.sv
`timescale 1ns/1ps
module bit_expander_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_bit = 1'b0;
  logic in_mode = 1'b0;
  logic out_valid;
  logic out_bit;

  int testsRun = 0;
  int testsFailed = 0;

  logic  expBits [$];
  string expTags [$];

  logic burstOn = 1'b0;
  logic burstStarted = 1'b0;
  logic monPhase = 1'b0;
  logic prevReady = 1'b1;
  logic sawStall = 1'b0;
  logic sawTrailRelease = 1'b0;
  logic monitorOn = 1'b0;

  always #2.5 clk = ~clk;

  bit_expander #(.DEPTH(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_mode(in_mode), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // expected pair per requirement R2 / R3
  task automatic sendBit(input logic b, input logic m);
    string tag;
    tag = m ? "R3" : "R2";
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_mode = m;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (m) begin
      expBits.push_back(~b); expTags.push_back(tag);
      expBits.push_back(1'b1); expTags.push_back(tag);
    end else begin
      expBits.push_back(b); expTags.push_back(tag);
      expBits.push_back(1'b0); expTags.push_back(tag);
    end
    @(posedge clk);
  endtask

  task automatic dropValid();
    @(negedge clk);
    in_valid = 1'b0; in_bit = 1'b0; in_mode = ~in_mode;
  endtask

  task automatic drain();
    while (expBits.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares against the scoreboard every cycle
  always @(negedge clk) begin
    #1;
    if (monitorOn) begin
      if (in_valid && !in_ready) sawStall = 1'b1;
      if (in_ready && !prevReady && in_valid && out_valid && monPhase) sawTrailRelease = 1'b1;
      prevReady = in_ready;
      if (monPhase && !out_valid) check("R4 trail bit missing", out_valid, 1'b1);
      if (out_valid) begin
        if (burstOn) burstStarted = 1'b1;
        if (expBits.size() == 0) begin
          check("R5 unexpected output", out_valid, 1'b0);
        end else begin
          check({expTags[0], " data"}, out_bit, expBits[0]);
          void'(expBits.pop_front());
          void'(expTags.pop_front());
        end
        monPhase = ~monPhase;
      end else begin
        if (out_bit !== 1'b0) check("R5 idle out_bit", out_bit, 1'b0);
        if (burstOn && burstStarted && expBits.size() != 0)
          check("R9 gap in stream", out_valid, 1'b1);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 out_valid in reset", out_valid, 1'b0);
    check("R1 out_bit in reset", out_bit, 1'b0);
    check("R1 in_ready in reset", in_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 out_valid after reset", out_valid, 1'b0);
    check("R1 in_ready after reset", in_ready, 1'b1);
    monitorOn = 1'b1;

    // R10 latency plus R2/R3 isolated bits
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        sendBit(b[0], m[0]);
        dropValid();
        #1;
        check("R10 first bit next cycle", out_valid, 1'b1);
        drain();
        check("R5 idle after drain", out_valid, 1'b0);
      end
    end

    // R6/R7/R9 saturated burst, zero insert
    burstOn = 1'b1; burstStarted = 1'b0;
    for (int i = 0; i < 16; i++) sendBit(((i * 5) % 3) == 1, 1'b0);
    dropValid();
    drain();
    burstOn = 1'b0;
    check("R6 stall seen", sawStall, 1'b1);
    check("R7 slot freed on trail bit", sawTrailRelease, 1'b1);

    // R8/R9 saturated burst, mode changes per bit while symbols queued
    burstOn = 1'b1; burstStarted = 1'b0;
    for (int i = 0; i < 20; i++) sendBit(i[1], i[0] ^ i[2]);
    dropValid();
    drain();
    burstOn = 1'b0;

    // R8 all signed-unit bits queued, then mode flipped while draining
    for (int i = 0; i < 4; i++) sendBit(i[0], 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_mode = 1'b0;
    drain();

    // R5 long idle
    repeat (5) @(negedge clk);
    #1;
    check("R5 idle out_valid", out_valid, 1'b0);
    check("R5 idle out_bit", out_bit, 1'b0);
    check("R6 queue fully drained", expBits.size() == 0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule